// File: doc/BRIEF.md
# Ternary Test Cube Merger

This block folds a stream of partially specified test cubes into a single generator vector. Each cube is `WIDTH` positions wide. Every position carries a 2-bit symbol:

| Symbol | Meaning | Code |
|--------|---------|------|
| X | don't care | `00` |
| 0 | specified 0 | `01` |
| 1 | specified 1 | `10` |
| U | conflict | `11` |

With this encoding the merge is a bitwise OR of the running generator and the incoming cube. A position therefore moves from X to a binary value the first time a cube specifies it. It moves to U as soon as both binary values have been seen there, and it stays U until the next start.

A run opens with a start pulse and closes with a done strobe. The done strobe latches four results:
- the generator;
- the number of conflict positions;
- a flag that is set when that number exceeds the permitted limit;
- the number of expanded patterns the generator needs, which is two to the power of the conflict count.

Each position of the latched generator is also given a weight class. A downstream pattern expander uses it to pick a fixed 0, a fixed 1, a random bit (weight one half) or a free bit.

Top module: `cube_merge_unit`

## Requirements
- R1: After reset the outputs are as follows: `gen_o` is all X (`00`), `conf_cnt_o` is 0, `over_limit_o` is 0, `pat_cnt_o` is 1, every `weight_o` field is `11`, and `res_valid_o` is 0.
- R2: A position merges to 0 (`01`) when every cube of the run holds 0 or X there and at least one holds 0.
- R3: A position merges to 1 (`10`) when every cube of the run holds 1 or X there and at least one holds 1.
- R4: A position that no cube of the run specifies stays X (`00`).
- R5: A position that has seen both 0 and 1 in a run is U (`11`). It stays U for the rest of the run, whatever later cubes hold.
- R6: A start pulse discards the running generator. A cube presented with `cube_valid_i` in the same cycle as start becomes the first cube of the new run.
- R7: Results update only at a done strobe, and they include a cube presented in the same cycle. `res_valid_o` is set by done and cleared by start; done wins if both occur in the same cycle.
- R8: `conf_cnt_o` equals the number of U positions in the latched generator.
- R9: `over_limit_o` is 1 exactly when `conf_cnt_o` exceeds `UMAX` (default 3).
- R10: `pat_cnt_o` is 2 to the power of `conf_cnt_o` when the limit is not exceeded, and 0 when it is.
- R11: Weight field i of `weight_o` (bits 2i+1:2i) encodes the weight class of position i of the latched generator:

  | Position symbol | Weight class | Field |
  |-----------------|--------------|-------|
  | 0 | weight 0 | `00` |
  | U | weight one half | `01` |
  | 1 | weight 1 | `10` |
  | X | free | `11` |

- R12: While `cube_valid_i` is low, the value on `cube_i` has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new run and clears the running generator |
| cube_valid_i | input | 1 | `cube_i` carries a cube this cycle |
| cube_i | input | 2*WIDTH | Cube; position i is in bits 2i+1:2i |
| done_i | input | 1 | Latches the results of the run |
| gen_o | output | 2*WIDTH | Latched generator |
| conf_cnt_o | output | $clog2(WIDTH+1) | Number of U positions |
| over_limit_o | output | 1 | Conflict count exceeds UMAX |
| pat_cnt_o | output | UMAX+1 | Number of expanded patterns, or 0 when over the limit |
| weight_o | output | 2*WIDTH | Weight class for each position |
| res_valid_o | output | 1 | Results latched since the last start |

## Verification
The hardest situation to reach from the ports is a conflict that later cubes try to undo. A position already at U receives further cubes holding a single binary value, and the run is also left open across idle cycles with `cube_i` set to all ones. Directed sequences build such a conflict first. They then keep feeding cubes before the done strobe, so that a design which lets U decay, or which merges while `cube_valid_i` is low, produces a visibly different generator. The table also places the start cube and the done cube in the same cycles as their strobes. This exercises the case where the boundary cube is either lost or double-counted.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef logic [1:0] sym_t;

  localparam sym_t SYM_X    = 2'b00;
  localparam sym_t SYM_ZERO = 2'b01;
  localparam sym_t SYM_ONE  = 2'b10;
  localparam sym_t SYM_CONF = 2'b11;

  localparam logic [1:0] WT_ZERO = 2'b00;
  localparam logic [1:0] WT_HALF = 2'b01;
  localparam logic [1:0] WT_ONE  = 2'b10;
  localparam logic [1:0] WT_FREE = 2'b11;

  // Fold one symbol into an accumulated symbol.
  function automatic sym_t sym_merge(input sym_t acc, input sym_t inc);
    return acc | inc;
  endfunction

  function automatic logic sym_is_conf(input sym_t s);
    return s == SYM_CONF;
  endfunction

  // Map a generator symbol to its weight class.
  function automatic logic [1:0] sym_weight(input sym_t s);
    logic [1:0] w;
    case (s)
      SYM_ZERO: w = WT_ZERO;
      SYM_ONE:  w = WT_ONE;
      SYM_CONF: w = WT_HALF;
      default:  w = WT_FREE;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cmu_accum.sv
module cmu_accum
  import cmu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cube_valid_i,
  input  logic [2*WIDTH-1:0] cube_i,
  output logic [2*WIDTH-1:0] acc_q,
  output logic [2*WIDTH-1:0] acc_nxt
);
  localparam int VW = 2 * WIDTH;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    sym_t base_s;
    sym_t inc_s;
    assign base_s = start_i ? SYM_X : acc_q[2*i +: 2];
    assign inc_s  = cube_valid_i ? cube_i[2*i +: 2] : SYM_X;
    assign acc_nxt[2*i +: 2] = sym_merge(base_s, inc_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  logic unused_vw;
  assign unused_vw = (VW == 0);
endmodule

// File: rtl/cmu_conf_count.sv
module cmu_conf_count
  import cmu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic [2*WIDTH-1:0] vec_i,
  output logic [CW-1:0]      cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      cnt_o = cnt_o + CW'(sym_is_conf(vec_i[2*i +: 2]));
    end
  end
endmodule

// File: rtl/cmu_weight_map.sv
module cmu_weight_map
  import cmu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-1:0] gen_i,
  output logic [2*WIDTH-1:0] wt_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_wt
    assign wt_o[2*i +: 2] = sym_weight(gen_i[2*i +: 2]);
  end
endmodule

// File: rtl/cube_merge_unit.sv
module cube_merge_unit
  import cmu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int UMAX  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       cube_valid_i,
  input  logic [2*WIDTH-1:0]         cube_i,
  input  logic                       done_i,
  output logic [2*WIDTH-1:0]         gen_o,
  output logic [$clog2(WIDTH+1)-1:0] conf_cnt_o,
  output logic                       over_limit_o,
  output logic [UMAX:0]              pat_cnt_o,
  output logic [2*WIDTH-1:0]         weight_o,
  output logic                       res_valid_o
);
  localparam int VW = 2 * WIDTH;
  localparam int CW = $clog2(WIDTH + 1);
  localparam int PW = UMAX + 1;
  localparam logic [CW-1:0] UMAX_C = CW'(UMAX);

  // Named internal events for the checker.
  logic [VW-1:0] acc_q;
  logic [VW-1:0] acc_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          latch_fire;

  logic [VW-1:0] gen_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  assign latch_fire = done_i;

  cmu_accum #(.WIDTH(WIDTH)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cube_valid_i (cube_valid_i),
    .cube_i       (cube_i),
    .acc_q        (acc_q),
    .acc_nxt      (acc_nxt)
  );

  cmu_conf_count #(.WIDTH(WIDTH), .CW(CW)) u_count (
    .vec_i (acc_nxt),
    .cnt_o (cnt_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (latch_fire) begin
        gen_q <= acc_nxt;
        cnt_q <= cnt_nxt;
      end
      if (latch_fire)   valid_q <= 1'b1;
      else if (start_i) valid_q <= 1'b0;
    end
  end

  cmu_weight_map #(.WIDTH(WIDTH)) u_wmap (
    .gen_i (gen_q),
    .wt_o  (weight_o)
  );

  assign gen_o        = gen_q;
  assign conf_cnt_o   = cnt_q;
  assign over_limit_o = (cnt_q > UMAX_C);
  assign pat_cnt_o    = over_limit_o ? '0 : (PW'(1) << cnt_q);
  assign res_valid_o  = valid_q;
endmodule

// File: rtl/cube_merge_unit_chk.sv
module cube_merge_unit_chk #(
  parameter int WIDTH = 8,
  parameter int UMAX  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       cube_valid_i,
  input logic                       done_i,
  input logic [2*WIDTH-1:0]         acc_q,
  input logic [2*WIDTH-1:0]         gen_o,
  input logic [$clog2(WIDTH+1)-1:0] conf_cnt_o,
  input logic                       over_limit_o,
  input logic [UMAX:0]              pat_cnt_o,
  input logic                       res_valid_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] UMAX_C = CW'(UMAX);

  // R5: without a start, no accumulated symbol bit ever drops
  p_acc_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((acc_q | $past(acc_q)) == acc_q));

  // R6: a start with no cube leaves an all-X accumulator
  p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cube_valid_i) |=> (acc_q == '0));

  // R12: no start and no valid cube leaves the accumulator unchanged
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !cube_valid_i) |=> $stable(acc_q));

  // R7: results are valid after a done strobe
  p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> res_valid_o);

  // R7: results hold between done strobes
  p_gen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> ($stable(gen_o) && $stable(conf_cnt_o)));

  // R9: the over-limit flag agrees with the count
  p_over_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit_o |-> (conf_cnt_o > UMAX_C));

  // R10: the pattern count is zero when over the limit
  p_pat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit_o |-> (pat_cnt_o == '0));

  // R10: the pattern count is a power of two within the limit
  p_pat_pow2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !over_limit_o |-> ($countones(pat_cnt_o) == 1));
endmodule

bind cube_merge_unit cube_merge_unit_chk #(.WIDTH(WIDTH), .UMAX(UMAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cube_valid_i (cube_valid_i),
  .done_i       (done_i),
  .acc_q        (acc_q),
  .gen_o        (gen_o),
  .conf_cnt_o   (conf_cnt_o),
  .over_limit_o (over_limit_o),
  .pat_cnt_o    (pat_cnt_o),
  .res_valid_o  (res_valid_o)
);

// File: tb/cube_merge_unit_test.sv
module cube_merge_unit_test;
  localparam int W  = 8;
  localparam int UM = 3;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cube_valid_i = 1'b0;
  logic [15:0] cube_i = '0;
  logic        done_i = 1'b0;
  logic [15:0] gen_o;
  logic [3:0]  conf_cnt_o;
  logic        over_limit_o;
  logic [3:0]  pat_cnt_o;
  logic [15:0] weight_o;
  logic        res_valid_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cube_merge_unit #(.WIDTH(W), .UMAX(UM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cube_valid_i(cube_valid_i),
    .cube_i(cube_i), .done_i(done_i), .gen_o(gen_o), .conf_cnt_o(conf_cnt_o),
    .over_limit_o(over_limit_o), .pat_cnt_o(pat_cnt_o), .weight_o(weight_o),
    .res_valid_o(res_valid_o)
  );

  // Each table row: cube0, cube1, cube2 and the expected generator (hand-derived).
  localparam logic [63:0] TBL [NT] = '{
    {16'h5555, 16'h0000, 16'h0000, 16'h5555},
    {16'hAAAA, 16'h0000, 16'h0000, 16'hAAAA},
    {16'h5555, 16'hAAAA, 16'h0000, 16'hFFFF},
    {16'h0001, 16'h0002, 16'h0040, 16'h0043},
    {16'h0015, 16'h002A, 16'h0000, 16'h003F},
    {16'h0055, 16'h00AA, 16'h0000, 16'h00FF},
    {16'h9000, 16'h0000, 16'h8000, 16'h9000},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000}
  };
  localparam int ECNT [NT] = '{0, 0, 8, 1, 3, 4, 0, 0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Weight class model: 0 -> 00, half -> 01, 1 -> 10, free -> 11.
  function automatic logic [15:0] model_wt(input logic [15:0] g);
    logic [15:0] r;
    for (int i = 0; i < W; i++) begin
      logic lo, hi;
      lo = g[2*i];
      hi = g[2*i+1];
      if (lo && hi)  r[2*i +: 2] = 2'b01;
      else if (hi)   r[2*i +: 2] = 2'b10;
      else if (lo)   r[2*i +: 2] = 2'b00;
      else           r[2*i +: 2] = 2'b11;
    end
    return r;
  endfunction

  function automatic logic [3:0] model_pat(input int cnt);
    if (cnt > UM) return 4'd0;
    return 4'(2 ** cnt);
  endfunction

  task automatic drive(input logic st, input logic v, input logic [15:0] c, input logic dn);
    @(negedge clk);
    start_i = st; cube_valid_i = v; cube_i = c; done_i = dn;
  endtask

  task automatic idle();
    @(negedge clk);
    start_i = 0; cube_valid_i = 0; cube_i = '0; done_i = 0;
  endtask

  task automatic check_result(input string tag, input logic [15:0] g, input int cnt);
    check({tag, " R8 count"}, 32'(conf_cnt_o), 32'(cnt));
    check({tag, " R9 over"}, 32'(over_limit_o), 32'(cnt > UM));
    check({tag, " R10 patterns"}, 32'(pat_cnt_o), 32'(model_pat(cnt)));
    check({tag, " R11 weights"}, 32'(weight_o), 32'(model_wt(g)));
    check({tag, " R7 valid"}, 32'(res_valid_o), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 gen", 32'(gen_o), 32'h0);
    check("R1 count", 32'(conf_cnt_o), 32'd0);
    check("R1 over", 32'(over_limit_o), 32'd0);
    check("R1 patterns", 32'(pat_cnt_o), 32'd1);
    check("R1 weights", 32'(weight_o), 32'hFFFF);
    check("R1 valid", 32'(res_valid_o), 32'd0);
    rst_n = 1'b1;

    // Table: R2 R3 R4 R5 (rows 2-5), R6 start cube, R12 ignored all-ones, R7 done cube
    for (int t = 0; t < NT; t++) begin
      drive(1, 1, TBL[t][63:48], 0);
      drive(0, 1, TBL[t][47:32], 0);
      check("R7 valid cleared by start", 32'(res_valid_o), 32'd0);
      drive(0, 0, 16'hFFFF, 0);
      drive(0, 1, TBL[t][31:16], 1);
      idle();
      check($sformatf("R2/R3/R4/R5/R6/R12 gen row%0d", t), 32'(gen_o), 32'(TBL[t][15:0]));
      check_result($sformatf("row%0d", t), TBL[t][15:0], ECNT[t]);
    end

    // R5: conflict stays after later single-valued cubes
    drive(1, 1, 16'h0001, 0);
    drive(0, 1, 16'h0002, 0);
    drive(0, 1, 16'h0001, 0);
    drive(0, 1, 16'h0000, 1);
    idle();
    check("R5 sticky gen", 32'(gen_o), 32'h0003);
    check_result("R5 sticky", 16'h0003, 1);

    // R7: no update without done; R5 conflict survives further cubes
    drive(0, 1, 16'h5555, 0);
    drive(0, 1, 16'h5555, 0);
    idle();
    check("R7 hold gen", 32'(gen_o), 32'h0003);
    drive(0, 0, 16'hAAAA, 1);
    idle();
    check("R5 R12 gen after more cubes", 32'(gen_o), 32'h5557);
    check_result("R5 more", 16'h5557, 1);

    // R6: start alone discards the run
    drive(1, 0, 16'hFFFF, 0);
    drive(0, 0, 16'hFFFF, 1);
    idle();
    check("R6 cleared gen", 32'(gen_o), 32'h0000);
    check_result("R6 cleared", 16'h0000, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule